// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block is a unified instruction and data cache. It sits between a CPU-side word port and a slower memory-side port. The array has two ways of 128 sets, and each line holds eight 32-bit words, which gives 8 kB of storage. Each way keeps a tag, a valid bit and a dirty bit for every set. Each set also keeps one least-recently-used bit, and that bit picks the way to replace on a miss.

A cacheable hit finishes in the same cycle the request is presented, so back-to-back hits run at one access per clock. On a miss, the block first writes back the victim line if that line is valid and dirty. It then fetches the new line as an eight-beat burst, and the request completes from the array on the following cycle. A per-access `cpu_cacheable` input sends an access straight to memory. Such a bypass access costs one extra wait state.

Both ports follow a valid/ready handshake, and a transfer happens on a rising edge where valid and ready are both high.

On the CPU side, the requester raises `cpu_valid` and holds `cpu_we`, `cpu_cacheable`, `cpu_addr` and `cpu_wdata` stable until `cpu_ready` is high. Read data is valid in that same cycle.

On the memory side, the block holds `mem_valid` and every request field stable until the memory asserts `mem_ready`, which acknowledges one word. The memory may stall for any number of cycles.

Callers must not bypass-write an address whose line is held in the cache. Keeping the cacheable map consistent is the job of the logic outside this block.

Top module: `two_way_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_valid` are low while no request is presented, and the first cacheable access to any address is a miss.
- R2: A byte address splits into word offset [4:2], set index [11:5] and tag [31:12], so addresses 4096 bytes apart (1024 words) compete for the same set.
- R3: A cacheable hit asserts `cpu_ready` in the cycle the request is presented, with no memory traffic.
- R4: A line fill issues eight memory reads (`mem_we`=0) to the missing line, starting at word 0 and ascending by 4 bytes.
- R5: When the victim is valid and dirty, its eight words are written (`mem_we`=1) to the victim's own line address in ascending order before the fill, carrying the line's current contents.
- R6: A clean or invalid victim is replaced with no write-back.
- R7: A write hit to any single word marks the whole line dirty, so its later eviction writes back all eight words.
- R8: On a miss the victim is the way not used by the most recent hit or fill in that set, so the most recently used line survives.
- R9: A write miss allocates the line by fill and then merges the write data, so a later read of that word hits and returns the written value.
- R10: A non-cacheable access performs exactly one memory transfer with the CPU's address, direction and data, does not touch the array, and completes after memory latency plus one extra cycle. Its read data is the memory word.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R12: Every CPU read returns the most recent value written to that address, through any mix of hits, misses, evictions and bypass accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_cacheable | input | 1 | 1 = use the cache, 0 = bypass to memory |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or acknowledges one word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The bench targets the places where replacement state goes wrong. It drives four tags into the same set, both through the 1024-word alias and at random, so a design that replaced the wrong way, or failed to flip the LRU bit on a hit, would miss on a line that should survive or would evict the recently used line. It also writes a single word and then evicts the line: a design that marked only that word dirty, or skipped the write-back, would leave stale data that the following reads expose. The bench counts the cycles of bypass accesses, so a missing or doubled wait state shows up. Random memory stalls would catch any request field that drifts before the memory acknowledges it.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_BYP_WAIT,
    ST_BYP
  } ctrl_state_e;
endpackage

// File: rtl/cache_tags.sv
module cache_tags #(
  parameter int SET_W = 7,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       hit_vec,
  output logic             lru_way,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             mark_dirty,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] rd_tag [2];
  logic [1:0]       rd_valid;
  logic [1:0]       rd_dirty;
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    always_ff @(posedge clk) begin
      if (fill_en && (fill_way == 1'(w))) tag_q[idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_en && (fill_way == 1'(w))) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (touch_en && mark_dirty && (touch_way == 1'(w))) begin
        dirty_q[idx] <= 1'b1;
      end
    end

    assign rd_tag[w]   = tag_q[idx];
    assign rd_valid[w] = valid_q[idx];
    assign rd_dirty[w] = dirty_q[idx];
    assign hit_vec[w]  = valid_q[idx] && (tag_q[idx] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        lru_q      <= '0;
    else if (fill_en)  lru_q[idx] <= ~fill_way;
    else if (touch_en) lru_q[idx] <= ~touch_way;
  end

  assign lru_way   = lru_q[idx];
  assign vic_valid = rd_valid[lru_way];
  assign vic_dirty = rd_dirty[lru_way];
  assign vic_tag   = rd_tag[lru_way];

  // R2: one address never lives in both ways of its set
  p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/cache_data.sv
module cache_data #(
  parameter int SET_W  = 7,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_word [2],
  input  logic              wb_way,
  input  logic [OFF_W-1:0]  wb_off,
  output logic [DATA_W-1:0] wb_word,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << (SET_W + OFF_W);

  logic [DATA_W-1:0] wb_sel [2];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) mem_q[{idx, wr_off}] <= wr_data;
    end

    assign rd_word[w] = mem_q[{idx, rd_off}];
    assign wb_sel[w]  = mem_q[{idx, wb_off}];
  end

  assign wb_word = wb_sel[wb_way];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 7,
  parameter int OFF_W  = 3,
  parameter int TAG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic              cpu_cacheable,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [1:0]        hit_vec,
  input  logic              lru_way,
  input  logic              vic_valid,
  input  logic              vic_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  input  logic [DATA_W-1:0] hit_word,
  input  logic [DATA_W-1:0] wb_word,
  output logic              touch_en,
  output logic              touch_way,
  output logic              mark_dirty,
  output logic              fill_en,
  output logic              vic_way,
  output logic [OFF_W-1:0]  cnt,
  output logic              dwr_en,
  output logic              dwr_way,
  output logic [OFF_W-1:0]  dwr_off,
  output logic [DATA_W-1:0] dwr_data
);
  localparam int          LOW_W    = ADDR_W - TAG_W - SET_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST = '1;

  ctrl_state_e      state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic             vic_q, vic_d;

  logic [SET_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic             hit_way;

  assign idx     = cpu_addr[LOW_W+OFF_W +: SET_W];
  assign off     = cpu_addr[LOW_W +: OFF_W];
  assign tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];
  assign vic_way = vic_q;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vic_q   <= vic_d;
    end
  end

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    vic_d      = vic_q;
    cpu_ready  = 1'b0;
    cpu_rdata  = hit_word;
    mem_valid  = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    touch_en   = 1'b0;
    touch_way  = hit_way;
    mark_dirty = 1'b0;
    fill_en    = 1'b0;
    dwr_en     = 1'b0;
    dwr_way    = hit_way;
    dwr_off    = off;
    dwr_data   = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (!cpu_cacheable) begin
            state_d = ST_BYP_WAIT;
          end else if (hit) begin
            cpu_ready  = 1'b1;
            touch_en   = 1'b1;
            mark_dirty = cpu_we;
            dwr_en     = cpu_we;
          end else begin
            vic_d   = lru_way;
            cnt_d   = '0;
            state_d = (vic_valid && vic_dirty) ? ST_WB : ST_FILL;
          end
        end
      end
      ST_WB: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {vic_tag, idx, cnt_q, {LOW_W{1'b0}}};
        mem_wdata = wb_word;
        if (mem_ready) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {tag, idx, cnt_q, {LOW_W{1'b0}}};
        if (mem_ready) begin
          dwr_en   = 1'b1;
          dwr_way  = vic_q;
          dwr_off  = cnt_q;
          dwr_data = mem_rdata;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            fill_en = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_BYP_WAIT: state_d = ST_BYP;
      ST_BYP: begin
        mem_valid = 1'b1;
        mem_we    = cpu_we;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        if (mem_ready) begin
          cpu_ready = 1'b1;
          cpu_rdata = mem_rdata;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // R11: a stalled memory request keeps every field
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R10: the bypass request waits one cycle before reaching memory
  p_bypass_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cpu_valid && !cpu_cacheable) |=> !mem_valid);

  // R5: write-back beats step through the line one word at a time
  p_wb_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB && mem_ready && cnt_q != LAST) |=>
      (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(4)));

  // R3: a cacheable completion never coincides with memory traffic
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_cacheable) |-> !mem_valid);

  // R3: completion only answers a presented request
  p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
endmodule

// File: rtl/two_way_cache.sv
module two_way_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SET_W  = 7,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic              cpu_cacheable,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LOW_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W - LOW_W;

  logic [1:0]        hit_vec;
  logic              lru_way, vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic              touch_en, touch_way, mark_dirty, fill_en, vic_way;
  logic [OFF_W-1:0]  cnt;
  logic              dwr_en, dwr_way;
  logic [OFF_W-1:0]  dwr_off;
  logic [DATA_W-1:0] dwr_data, wb_word, hit_word;
  logic [DATA_W-1:0] rd_word [2];

  logic [SET_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [TAG_W-1:0] tag;
  assign idx      = cpu_addr[LOW_W+OFF_W +: SET_W];
  assign off      = cpu_addr[LOW_W +: OFF_W];
  assign tag      = cpu_addr[ADDR_W-1 -: TAG_W];
  assign hit_word = rd_word[hit_vec[1]];

  cache_tags #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .idx, .lk_tag(tag), .hit_vec, .lru_way, .vic_valid,
    .vic_dirty, .vic_tag, .touch_en, .touch_way, .mark_dirty, .fill_en,
    .fill_way(vic_way), .fill_tag(tag)
  );

  cache_data #(.SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk, .idx, .rd_off(off), .rd_word, .wb_way(vic_way), .wb_off(cnt),
    .wb_word, .wr_en(dwr_en), .wr_way(dwr_way), .wr_off(dwr_off),
    .wr_data(dwr_data)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W),
               .OFF_W(OFF_W), .TAG_W(TAG_W)) u_ctrl (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_cacheable, .cpu_addr, .cpu_wdata,
    .cpu_ready, .cpu_rdata, .mem_valid, .mem_we, .mem_addr, .mem_wdata,
    .mem_ready, .mem_rdata, .hit_vec, .lru_way, .vic_valid, .vic_dirty,
    .vic_tag, .hit_word, .wb_word, .touch_en, .touch_way, .mark_dirty,
    .fill_en, .vic_way, .cnt, .dwr_en, .dwr_way, .dwr_off, .dwr_data
  );
endmodule

// File: tb/two_way_cache_tb.sv
`timescale 1ns/1ps
module two_way_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0, cpu_cacheable = 1'b1;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  two_way_cache u_dut (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_cacheable, .cpu_addr, .cpu_wdata,
    .cpu_ready, .cpu_rdata, .mem_valid, .mem_we, .mem_addr, .mem_wdata,
    .mem_ready, .mem_rdata
  );

  int n_chk = 0, n_fail = 0;
  int lat = 1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : init_val(a);
  endfunction
  function automatic logic [31:0] ref_rd(logic [31:0] a);
    return ref_m.exists(a) ? ref_m[a] : init_val(a);
  endfunction

  // memory model: per-word ack after lat cycles, transfer log
  bit          log_we [$];
  logic [31:0] log_addr [$];
  logic [31:0] log_data [$];
  int          wcnt = 0;
  logic [31:0] prv_addr, prv_wdata;
  logic        prv_we;

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_valid) begin
      if (wcnt > 0) begin
        chk(mem_addr == prv_addr && mem_we == prv_we && mem_wdata == prv_wdata,
            "R11", "stalled request drifted", mem_addr, prv_addr);
      end
      prv_addr = mem_addr; prv_we = mem_we; prv_wdata = mem_wdata;
      if (wcnt >= lat) begin
        log_we.push_back(mem_we);
        log_addr.push_back(mem_addr);
        log_data.push_back(mem_wdata);
        if (mem_we) mem_m[mem_addr] = mem_wdata;
        mem_rdata = mem_rd(mem_addr);
        mem_ready = 1'b1;
      end else begin
        wcnt++;
      end
    end
  end

  // bench view of the cache contents, built from the requirements
  logic [19:0] bm_tag [2][128];
  bit          bm_v [2][128];
  bit          bm_d [2][128];
  bit          bm_lru [128];

  task automatic access(bit we, bit cb, logic [31:0] addr, logic [31:0] wd, string req);
    bit          exp_we [$];
    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    int          start, cyc, exp_cyc, idx, w;
    logic [19:0] tg;
    logic [31:0] rd, exp_rd;
    bit          hit;
    idx = int'(addr[11:5]);
    tg  = addr[31:12];
    exp_rd = cb ? ref_rd({addr[31:2], 2'b00}) : mem_rd(addr);
    exp_cyc = -1;
    hit = 1'b0; w = 0;
    if (!cb) begin
      exp_we.push_back(we); exp_addr.push_back(addr); exp_data.push_back(wd);
      exp_cyc = 2 + lat;
    end else begin
      for (int k = 0; k < 2; k++)
        if (bm_v[k][idx] && bm_tag[k][idx] == tg) begin hit = 1'b1; w = k; end
      if (hit) begin
        exp_cyc = 0;
      end else begin
        w = int'(bm_lru[idx]);
        if (bm_v[w][idx] && bm_d[w][idx])
          for (int k = 0; k < 8; k++) begin
            logic [31:0] va;
            va = {bm_tag[w][idx], addr[11:5], 3'(k), 2'b00};
            exp_we.push_back(1'b1); exp_addr.push_back(va); exp_data.push_back(ref_rd(va));
          end
        for (int k = 0; k < 8; k++) begin
          exp_we.push_back(1'b0);
          exp_addr.push_back({tg, addr[11:5], 3'(k), 2'b00});
          exp_data.push_back(32'h0);
        end
      end
    end
    start = log_addr.size();
    cpu_valid = 1'b1; cpu_we = we; cpu_cacheable = cb; cpu_addr = addr; cpu_wdata = wd;
    #1;
    cyc = 0;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 1'b0;
    // checks
    chk(log_addr.size() - start == exp_addr.size(), req, "memory transfer count",
        32'(log_addr.size() - start), 32'(exp_addr.size()));
    if (log_addr.size() - start == exp_addr.size())
      for (int k = 0; k < exp_addr.size(); k++) begin
        chk(log_addr[start+k] == exp_addr[k] && log_we[start+k] == exp_we[k], req,
            "memory transfer address", log_addr[start+k], exp_addr[k]);
        if (exp_we[k])
          chk(log_data[start+k] == exp_data[k], req, "memory write data",
              log_data[start+k], exp_data[k]);
      end
    if (exp_cyc >= 0)
      chk(cyc == exp_cyc, req, "completion cycles", 32'(cyc), 32'(exp_cyc));
    if (!we) chk(rd == exp_rd, req, "read data", rd, exp_rd);
    // update the bench view
    if (cb) begin
      if (!hit) begin
        bm_tag[w][idx] = tg; bm_v[w][idx] = 1'b1; bm_d[w][idx] = 1'b0;
      end
      if (we) bm_d[w][idx] = 1'b1;
      bm_lru[idx] = (w == 0);
      if (we) ref_m[{addr[31:2], 2'b00}] = wd;
    end else if (we) begin
      ref_m[addr] = wd;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 128; s++) begin
      bm_lru[s] = 1'b0;
      for (int k = 0; k < 2; k++) begin bm_v[k][s] = 1'b0; bm_d[k][s] = 1'b0; bm_tag[k][s] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cpu_ready == 1'b0, "R1", "cpu_ready idle after reset", 32'(cpu_ready), 32'h0);
    chk(mem_valid == 1'b0, "R1", "mem_valid idle after reset", 32'(mem_valid), 32'h0);
    @(negedge clk);

    lat = 1;
    access(1'b0, 1'b1, 32'h0000_0000, 0, "R1");        // first access misses
    access(1'b0, 1'b1, 32'h0000_0004, 0, "R3");        // hit, same cycle
    access(1'b0, 1'b1, 32'h0000_1000, 0, "R2");        // word 1024 aliases set 0
    lat = 2;
    access(1'b1, 1'b1, 32'h0000_0008, 32'hDEAD_0008, "R7"); // one word dirties line
    access(1'b0, 1'b1, 32'h0000_2000, 0, "R6");        // clean victim, no write-back
    access(1'b0, 1'b1, 32'h0000_000C, 0, "R8");        // MRU line survived
    access(1'b0, 1'b1, 32'h0000_3000, 0, "R4");
    lat = 0;
    access(1'b0, 1'b1, 32'h0000_4000, 0, "R5");        // dirty line written back whole
    access(1'b0, 1'b1, 32'h0000_0008, 0, "R7");        // value survived eviction
    access(1'b1, 1'b1, 32'h0000_5024, 32'hCAFE_5024, "R9");
    access(1'b0, 1'b1, 32'h0000_5024, 0, "R9");
    access(1'b0, 1'b1, 32'h0000_5020, 0, "R9");
    lat = 3;
    access(1'b0, 1'b0, 32'h0008_0010, 0, "R10");
    access(1'b1, 1'b0, 32'h0008_0014, 32'h1234_5678, "R10");
    access(1'b0, 1'b0, 32'h0008_0014, 0, "R10");

    for (int n = 0; n < 800; n++) begin
      logic [31:0] a;
      bit cb, we;
      int sel;
      sel = int'($urandom_range(0, 3));
      cb = ($urandom_range(0, 99) < 85);
      we = $urandom_range(0, 1) == 1;
      a[31:12] = cb ? 20'($urandom_range(0, 3)) : 20'(32'h100 + $urandom_range(0, 1));
      a[11:5]  = (sel == 3) ? 7'd127 : 7'(sel);
      a[4:2]   = 3'($urandom_range(0, 7));
      a[1:0]   = 2'b00;
      lat = int'($urandom_range(0, 3));
      access(we, cb, a, $urandom(), "R12");
    end

    summary();
    $finish;
  end
endmodule